// File: doc/BRIEF.md
# Acknowledged-read asynchronous serial receiver

This block receives asynchronous serial frames on a single input line and delivers each 8-bit payload into a one-byte receive buffer. The frame is a low start bit, eight data bits with the least significant bit first, an optional parity bit, and one high stop bit. The line is oversampled by a clock-enable strobe running at `OVS` strobes per bit. The start bit is confirmed half a bit after its falling edge. Each later bit is sampled in the middle of its bit time.

Software controls the block through a small write port. One register holds the receive enable and the two interrupt enables. A command register takes strobes that acknowledge a read and clear the interrupt factor flags. The buffer stays occupied until software acknowledges it. If a frame finishes while the buffer is still occupied, the block flags an overrun, keeps the old byte, and does not raise the completion flag. Parity, overrun and framing errors each have their own sticky flag, and turning reception off clears all three.

Top module: `uart_ack_rx`

## Requirements
- R1: After reset the following are all 0: `rx_data`, `rx_on`, every flag and both interrupt outputs.
- R2: With reception on and the buffer free, a frame is stored in `rx_data` with bit 0 received first, and `done_flag` is set. The bits are: start bit low, 8 data bits, parity bit only when parity is selected, stop bit high.
- R3: A low pulse shorter than half a bit time is ignored, and the next valid frame is received correctly.
- R4: A frame whose stop bit reads low sets `frm_err` and `err_flag`, and its byte is still stored. The receiver does not look for a new start bit until the line is high again.
- R5: `par_mode` selects the parity check: 0 means none, 1 means even, 2 means odd. When a byte is taken into the buffer and its parity bit does not match, `par_err` and `err_flag` are set.
- R6: A frame that completes while the buffer is unacknowledged sets `ovr_err` and `err_flag`. In that case `rx_data` keeps the old byte and `done_flag` is not set.
- R7: Writing address 1 with bit 0 set acknowledges the buffer, so the next frame is stored normally.
- R8: Writing address 0 sets `rx_on` from bit 0. Writing bit 0 as 0 stops reception and clears `par_err`, `ovr_err` and `frm_err`. While reception is off, frames on the line change nothing.
- R9: Writing address 1 with bit 1 set clears `done_flag`. Writing address 1 with bit 2 set clears `err_flag`. Both flags are sticky until cleared this way.
- R10: `irq_done` is `done_flag` gated by address 0 bit 1. `irq_err` is `err_flag` gated by address 0 bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_tick | input | 1 | Oversampling strobe, OVS strobes per bit |
| rxd | input | 1 | Serial input line, idle high |
| par_mode | input | 2 | Static parity selection: 0 none, 1 even, 2 odd |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the control register, 1 selects the command register |
| wr_data | input | 3 | Write data |
| rx_data | output | 8 | Receive buffer |
| rx_on | output | 1 | Receive enable state |
| done_flag | output | 1 | Receive-complete factor flag |
| err_flag | output | 1 | Error interrupt factor flag |
| par_err | output | 1 | Parity error flag |
| ovr_err | output | 1 | Overrun error flag |
| frm_err | output | 1 | Framing error flag |
| irq_done | output | 1 | Receive-complete interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
A frame's results become visible on the first clock after the middle of its stop bit. That point is two synchronizer cycles plus up to one strobe after the line is sampled. The bench therefore queues its expectation only after it has driven the whole stop bit, which leaves about half a bit of margin. A register write takes effect at the clock edge after the strobe, and the interrupt outputs follow their flags in the same cycle. The bench compares one falling edge after each write. The scoreboard monitor pops each expected item and compares every output at a falling edge.

// File: rtl/uart_ack_rx_pkg.sv
package uart_ack_rx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CMD_W  = 3;
  localparam logic [1:0] PM_NONE = 2'd0;
  localparam logic [1:0] PM_EVEN = 2'd1;
  localparam logic [1:0] PM_ODD  = 2'd2;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_CMD  = 1'b1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD
  } rx_state_e;

  // parity bit a correct sender appends
  function automatic logic par_expected(logic [DATA_W-1:0] d, logic [1:0] mode);
    return (mode == PM_ODD) ? ~(^d) : (^d);
  endfunction

  function automatic logic par_used(logic [1:0] mode);
    return (mode == PM_EVEN) || (mode == PM_ODD);
  endfunction

  // LSB arrives first, so new bits enter at the top
  function automatic logic [DATA_W-1:0] shift_in(logic [DATA_W-1:0] sh, logic b);
    return {b, sh[DATA_W-1:1]};
  endfunction
endpackage

// File: rtl/uart_ack_rx_sync.sv
module uart_ack_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= {q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = q[STAGES-1];
endmodule

// File: rtl/uart_ack_rx_framer.sv
module uart_ack_rx_framer
  import uart_ack_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              rxd_s,
  input  logic [1:0]        par_mode,
  output logic              frame_done,
  output logic [DATA_W-1:0] frame_data,
  output logic              par_bit,
  output logic              stop_bit
);
  localparam int unsigned CW   = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int unsigned HALF = OVS / 2;
  localparam int unsigned BW   = $clog2(DATA_W);

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] sh;
  logic              mid_start;
  logic              bit_end;

  assign mid_start = tick && (cnt == CW'(HALF - 1));
  assign bit_end   = tick && (cnt == CW'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      bitn       <= '0;
      sh         <= '0;
      par_bit    <= 1'b0;
      stop_bit   <= 1'b1;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (!en) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (tick && !rxd_s) begin
              state <= ST_START;
              cnt   <= '0;
            end
          end
          ST_START: begin
            if (mid_start) begin
              cnt  <= '0;
              bitn <= '0;
              state <= rxd_s ? ST_IDLE : ST_DATA;
            end else if (tick) begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (bit_end) begin
              cnt  <= '0;
              sh   <= shift_in(sh, rxd_s);
              bitn <= bitn + 1'b1;
              if (bitn == BW'(DATA_W - 1))
                state <= par_used(par_mode) ? ST_PAR : ST_STOP;
            end else if (tick) begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (bit_end) begin
              cnt     <= '0;
              par_bit <= rxd_s;
              state   <= ST_STOP;
            end else if (tick) begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (bit_end) begin
              cnt        <= '0;
              stop_bit   <= rxd_s;
              frame_done <= 1'b1;
              state      <= rxd_s ? ST_IDLE : ST_HOLD;
            end else if (tick) begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_HOLD: begin
            if (rxd_s) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign frame_data = sh;

  // R8: switching reception off returns the framer to idle with no result
  p_off_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state == ST_IDLE) && !frame_done);

  // R4: a low stop bit parks the framer until the line is high
  p_low_stop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !stop_bit |-> state == ST_HOLD);

  // R3: a start that is high again at mid-bit produces no frame next cycle
  p_false_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en && (state == ST_START) && mid_start && rxd_s |=> state == ST_IDLE);
endmodule

// File: rtl/uart_ack_rx_status.sv
module uart_ack_rx_status
  import uart_ack_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [CMD_W-1:0]  wr_data,
  input  logic [1:0]        par_mode,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              par_bit,
  input  logic              stop_bit,
  output logic              rx_on,
  output logic [DATA_W-1:0] rx_data,
  output logic              done_flag,
  output logic              err_flag,
  output logic              par_err,
  output logic              ovr_err,
  output logic              frm_err,
  output logic              irq_done,
  output logic              irq_err
);
  logic ie_done, ie_err, held;
  logic ctrl_wr, cmd_wr, off_wr, ack_now, clr_done, clr_err;
  logic held_eff, ovr_evt, take_evt, par_bad, frm_bad, err_evt;

  assign ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
  assign cmd_wr   = wr_en && (wr_addr == ADDR_CMD);
  assign off_wr   = ctrl_wr && !wr_data[0];
  assign ack_now  = cmd_wr && wr_data[0];
  assign clr_done = cmd_wr && wr_data[1];
  assign clr_err  = cmd_wr && wr_data[2];

  assign held_eff = held && !ack_now;
  assign ovr_evt  = frame_done && held_eff;
  assign take_evt = frame_done && !held_eff;
  assign par_bad  = take_evt && par_used(par_mode) &&
                    (par_bit != par_expected(frame_data, par_mode));
  assign frm_bad  = frame_done && !stop_bit;
  assign err_evt  = ovr_evt || par_bad || frm_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_on <= 1'b0; ie_done <= 1'b0; ie_err <= 1'b0;
      held <= 1'b0; rx_data <= '0;
      done_flag <= 1'b0; err_flag <= 1'b0;
      par_err <= 1'b0; ovr_err <= 1'b0; frm_err <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        rx_on   <= wr_data[0];
        ie_done <= wr_data[1];
        ie_err  <= wr_data[2];
      end
      if (take_evt)     held <= 1'b1;
      else if (ack_now) held <= 1'b0;
      if (take_evt) rx_data <= frame_data;
      if (take_evt)      done_flag <= 1'b1;
      else if (clr_done) done_flag <= 1'b0;
      if (err_evt)      err_flag <= 1'b1;
      else if (clr_err) err_flag <= 1'b0;
      if (off_wr) begin
        par_err <= 1'b0; ovr_err <= 1'b0; frm_err <= 1'b0;
      end else begin
        if (par_bad) par_err <= 1'b1;
        if (ovr_evt) ovr_err <= 1'b1;
        if (frm_bad) frm_err <= 1'b1;
      end
    end
  end

  assign irq_done = done_flag && ie_done;
  assign irq_err  = err_flag && ie_err;

  // R6: an overrun keeps the old byte and raises the overrun flags
  p_ovr_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && held_eff && !off_wr |=> $stable(rx_data) && ovr_err && err_flag);

  // R6: the completion flag is not raised by an overrun frame
  p_ovr_no_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && held_eff && !done_flag |=> !done_flag);

  // R2: a frame with the buffer free is stored and flagged
  p_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !held_eff |=> done_flag && (rx_data == $past(frame_data)));

  // R8: switching reception off clears the three error flags
  p_off_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    off_wr |=> !par_err && !ovr_err && !frm_err);

  // R7: an acknowledge without a frame frees the buffer
  p_ack_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_now && !frame_done |=> !held);

  // R4: a low stop bit is recorded
  p_frm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !stop_bit && !off_wr |=> frm_err && err_flag);
endmodule

// File: rtl/uart_ack_rx.sv
module uart_ack_rx
  import uart_ack_rx_pkg::*;
#(
  parameter int unsigned OVS       = 16,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_tick,
  input  logic              rxd,
  input  logic [1:0]        par_mode,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [CMD_W-1:0]  wr_data,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_on,
  output logic              done_flag,
  output logic              err_flag,
  output logic              par_err,
  output logic              ovr_err,
  output logic              frm_err,
  output logic              irq_done,
  output logic              irq_err
);
  logic              rxd_s;
  logic              frame_done;
  logic [DATA_W-1:0] frame_data;
  logic              par_bit;
  logic              stop_bit;

  uart_ack_rx_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
  );

  uart_ack_rx_framer #(.OVS(OVS)) u_framer (
    .clk(clk), .rst_n(rst_n), .en(rx_on), .tick(samp_tick),
    .rxd_s(rxd_s), .par_mode(par_mode), .frame_done(frame_done),
    .frame_data(frame_data), .par_bit(par_bit), .stop_bit(stop_bit)
  );

  uart_ack_rx_status u_status (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .par_mode(par_mode), .frame_done(frame_done),
    .frame_data(frame_data), .par_bit(par_bit), .stop_bit(stop_bit),
    .rx_on(rx_on), .rx_data(rx_data), .done_flag(done_flag),
    .err_flag(err_flag), .par_err(par_err), .ovr_err(ovr_err),
    .frm_err(frm_err), .irq_done(irq_done), .irq_err(irq_err)
  );
endmodule

// File: tb/uart_ack_rx_bench.sv
`timescale 1ns/1ps
module uart_ack_rx_bench;
  localparam int OVS = 16;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = OVS * TICK_DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic samp_tick = 1'b0;
  logic rxd = 1'b1;
  logic [1:0] par_mode = 2'd0;
  logic wr_en = 1'b0;
  logic wr_addr = 1'b0;
  logic [2:0] wr_data = 3'd0;
  logic [7:0] rx_data;
  logic rx_on, done_flag, err_flag, par_err, ovr_err, frm_err, irq_done, irq_err;

  uart_ack_rx #(.OVS(OVS)) u_uart_ack_rx (
    .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick), .rxd(rxd),
    .par_mode(par_mode), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rx_data(rx_data), .rx_on(rx_on), .done_flag(done_flag), .err_flag(err_flag),
    .par_err(par_err), .ovr_err(ovr_err), .frm_err(frm_err),
    .irq_done(irq_done), .irq_err(irq_err)
  );

  always #2.5 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk); samp_tick = 1'b1;
      @(negedge clk); samp_tick = 1'b0;
      repeat (TICK_DIV - 2) @(negedge clk);
    end
  end

  typedef struct {
    string req;
    logic [7:0] data;
    logic on, done, err, par, ovr, frm, idone, ierr;
  } exp_t;
  exp_t q[$];

  int checks = 0;
  int errors = 0;
  bit all_sent = 0;

  // bench model of the register state
  logic [7:0] m_data = 8'h00;
  logic m_on = 0, m_ied = 0, m_iee = 0, m_held = 0;
  logic m_done = 0, m_err = 0, m_par = 0, m_ovr = 0, m_frm = 0;

  task automatic snap(input string req);
    exp_t e;
    e.req = req; e.data = m_data; e.on = m_on; e.done = m_done; e.err = m_err;
    e.par = m_par; e.ovr = m_ovr; e.frm = m_frm;
    e.idone = m_done & m_ied; e.ierr = m_err & m_iee;
    q.push_back(e);
  endtask

  task automatic cmp(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expectations and compares all outputs
  initial begin
    forever begin
      exp_t e;
      wait (q.size() > 0);
      e = q.pop_front();
      cmp(e.req, "rx_data", rx_data, e.data);
      cmp(e.req, "rx_on", rx_on, e.on);
      cmp(e.req, "done_flag", done_flag, e.done);
      cmp(e.req, "err_flag", err_flag, e.err);
      cmp(e.req, "par_err", par_err, e.par);
      cmp(e.req, "ovr_err", ovr_err, e.ovr);
      cmp(e.req, "frm_err", frm_err, e.frm);
      cmp(e.req, "irq_done", irq_done, e.idone);
      cmp(e.req, "irq_err", irq_err, e.ierr);
    end
  end

  task automatic wr(input logic a, input logic [2:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 1'b0) begin
      m_on = d[0]; m_ied = d[1]; m_iee = d[2];
      if (!d[0]) begin m_par = 0; m_ovr = 0; m_frm = 0; end
    end else begin
      if (d[0]) m_held = 0;
      if (d[1]) m_done = 0;
      if (d[2]) m_err = 0;
    end
  endtask

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  function automatic logic good_par(input logic [7:0] d, input logic [1:0] mode);
    logic odd_ones;
    odd_ones = ($countones(d) % 2) == 1;
    return (mode == 2'd2) ? !odd_ones : odd_ones;
  endfunction

  task automatic send(input logic [7:0] d, input logic flip, input logic stopv, input string req);
    logic used;
    used = (par_mode == 2'd1) || (par_mode == 2'd2);
    @(negedge clk);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (used) drive_bit(good_par(d, par_mode) ^ flip);
    drive_bit(stopv);
    if (!stopv) drive_bit(1'b1);
    rxd = 1'b1;
    if (m_on) begin
      if (m_held) begin
        m_ovr = 1; m_err = 1;
      end else begin
        m_data = d; m_held = 1; m_done = 1;
        if (used && flip) begin m_par = 1; m_err = 1; end
      end
      if (!stopv) begin m_frm = 1; m_err = 1; end
    end
    snap(req);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    snap("R1");
    wr(1'b0, 3'b111);
    snap("R8");
    send(8'hA5, 0, 1, "R2");         // plain reception, R10 irq_done high
    wr(1'b1, 3'b011);                 // ack and clear completion
    snap("R7");
    send(8'h3C, 0, 1, "R2");
    wr(1'b1, 3'b010);                 // clear completion, no ack
    send(8'h77, 0, 1, "R6");         // overrun
    wr(1'b0, 3'b110);                 // reception off
    snap("R8");
    send(8'h55, 0, 1, "R8");         // ignored while off
    wr(1'b1, 3'b101);                 // ack and clear error factor
    snap("R9");
    wr(1'b0, 3'b111);
    send(8'h0F, 0, 0, "R4");         // low stop bit
    send(8'h3C, 0, 1, "R4");         // overrun after framing frame
    wr(1'b1, 3'b111);
    wr(1'b0, 3'b110);
    wr(1'b0, 3'b111);
    snap("R9");
    par_mode = 2'd1;
    send(8'h96, 0, 1, "R5");
    wr(1'b1, 3'b111);
    send(8'h96, 1, 1, "R5");         // even parity mismatch
    wr(1'b0, 3'b110);
    wr(1'b1, 3'b111);
    wr(1'b0, 3'b111);
    par_mode = 2'd2;
    send(8'h81, 0, 1, "R5");
    wr(1'b1, 3'b111);
    send(8'h81, 1, 1, "R5");         // odd parity mismatch
    wr(1'b0, 3'b110);
    wr(1'b1, 3'b111);
    wr(1'b0, 3'b111);
    par_mode = 2'd0;
    rxd = 1'b0;                        // short low pulse
    repeat (OVS / 4 * TICK_DIV) @(negedge clk);
    rxd = 1'b1;
    repeat (BIT_CLKS * 2) @(negedge clk);
    snap("R3");
    send(8'hC3, 0, 1, "R3");
    wr(1'b1, 3'b111);
    wr(1'b0, 3'b001);                 // interrupts masked
    send(8'h24, 0, 1, "R10");
    wr(1'b0, 3'b011);
    snap("R10");
    wr(1'b1, 3'b010);
    snap("R9");
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule